// File: doc/BRIEF.md
# Maskable Interrupt Aggregation Controller

The block gathers interrupt events from a large set of FIFO channels and from a small group of miscellaneous sources. It folds them into one active-low, level-sensitive interrupt pin. Each event pulse is caught in a sticky status bit. Software reads these bits through a simple synchronous register bus, and a read clears the bits it returns. A bit that arrives in the same cycle as the read that clears it is kept for the next read.

The FIFO events are grouped into banks of `BANK_W` bits. An overview register gives one bit per bank, so an interrupt handler can go straight to the banks that hold pending events. Reading the overview register clears nothing. A FIFO event is only recorded when its channel mask bit is set. Miscellaneous events are always recorded, and their mask only decides whether they drive the pin. A global enable must be set before the pin can assert at all. A FIFO-group enable decides whether FIFO status reaches the pin.

With the defaults there are 64 FIFO channels in 8 banks of 8 bits, 8 miscellaneous sources and an 8-bit data bus. The register map is:

| Address | Register |
|---|---|
| 0x00 | control |
| 0x01 | misc mask |
| 0x02 | misc status |
| 0x03 | overview |
| 0x08+k | FIFO mask of bank k |
| 0x10+k | FIFO status of bank k |

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status, mask and control register reads 0, `bus_rdata` is 0 and `irq_n` is 1.
- R2: FIFO channel c maps to bit c mod 8 of bank c/8 (bank status at 0x10+bank, bank mask at 0x08+bank). A pulse on `fifo_evt[c]` sets that status bit only if its mask bit is 1 in the cycle of the pulse; otherwise the bit stays 0.
- R3: A pulse on `misc_evt[i]` sets bit i of the misc status register (0x02) whatever the misc mask (0x01) holds.
- R4: The overview register (0x03) has bit k set exactly when FIFO bank k holds at least one set bit. Reading it leaves every status bit unchanged.
- R5: A read strobe at a status address makes `bus_rdata` show, from the next cycle on, the register value before that edge, and the register is cleared at that edge.
- R6: An event that arrives in the cycle of a clearing read of its register stays latched and is returned by the following read.
- R7: `irq_n` is 0 exactly when control bit 0 (global enable) is 1 and either control bit 1 (FIFO-group enable) is 1 with some FIFO status bit whose mask bit is 1 set, or some misc status bit whose misc mask bit is 1 is set. The pin follows the registers in the same cycle.
- R8: Control bit 0 is the global enable and bit 1 is the FIFO-group enable. The control and mask registers read back what was last written, and control bits 7:2 read as 0. Unmapped addresses read 0.
- R9: Writes to the status and overview addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| fifo_evt | input | 64 | FIFO channel event pulses |
| misc_evt | input | 8 | Miscellaneous event pulses |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The assertions check these properties on every cycle:
- a masked-off FIFO channel never sets its status bit;
- no admitted FIFO or misc event is ever lost, including one that arrives during a clearing read;
- overview reads and bus writes never drop a status bit;
- overview and misc read data match the pre-edge register contents;
- the pin stays high without the global enable, and goes low when an enabled FIFO bit is pending.

Only the bench scenarios can show the full picture. These scenarios cover exact read-back of each register after long mixed sequences, the two-read sequence that surfaces an event caught during a clearing read, and the complete pin equation under random changes of masks and enables.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // Register addresses; the status banks and mask banks are each contiguous
   localparam int unsigned CTRL_ADDR      = 0;
   localparam int unsigned MISC_MASK_ADDR = 1;
   localparam int unsigned MISC_STAT_ADDR = 2;
   localparam int unsigned OVW_ADDR       = 3;
   localparam int unsigned FMASK_BASE     = 8;
   localparam int unsigned FSTAT_BASE     = 16;
   localparam int unsigned MAX_BANKS      = 8;

   // Control register fields, bit 0 = global enable, bit 1 = FIFO-group enable
   typedef struct packed {
      logic fifo_grp_en;
      logic glob_en;
   } irq_ctrl_t;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned W                = 8,
   parameter bit          MASK_GATES_LATCH = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] mask,
   input  logic         clr,
   output logic [W-1:0] stat
);

   logic [W-1:0] admit;

   generate
      if (W < 1) begin : g_bad_width
         $error("irq_status_bank: W must be at least 1");
      end
      if (MASK_GATES_LATCH) begin : g_gated
         assign admit = evt & mask;
      end else begin : g_free
         logic unused_mask;
         assign unused_mask = ^mask;
         assign admit = evt;
      end
   endgenerate

   // Clear first, then OR in new events, so an event during a read survives
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat <= '0;
      end else begin
         stat <= (clr ? '0 : stat) | admit;
      end
   end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_agg_pkg::*;
#(
   parameter int unsigned N_BANKS = 8,
   parameter int unsigned BANK_W  = 8,
   parameter int unsigned MISC_W  = 8,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned N_FIFO = N_BANKS * BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output irq_ctrl_t         ctrl,
   output logic [N_FIFO-1:0] fifo_mask,
   output logic [MISC_W-1:0] misc_mask
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr && addr == ADDR_W'(CTRL_ADDR)) begin
         ctrl <= irq_ctrl_t'(wdata[1:0]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         misc_mask <= '0;
      end else if (wr && addr == ADDR_W'(MISC_MASK_ADDR)) begin
         misc_mask <= wdata[MISC_W-1:0];
      end
   end

   generate
      for (genvar k = 0; k < N_BANKS; k++) begin : g_mask
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fifo_mask[k*BANK_W +: BANK_W] <= '0;
            end else if (wr && addr == ADDR_W'(FMASK_BASE + k)) begin
               fifo_mask[k*BANK_W +: BANK_W] <= wdata[BANK_W-1:0];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
   import irq_agg_pkg::*;
#(
   parameter int unsigned N_BANKS = 8,
   parameter int unsigned BANK_W  = 8,
   parameter int unsigned MISC_W  = 8,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned N_FIFO = N_BANKS * BANK_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               rd,
   input  irq_ctrl_t          ctrl,
   input  logic [N_FIFO-1:0]  fifo_mask,
   input  logic [N_FIFO-1:0]  fifo_stat,
   input  logic [MISC_W-1:0]  misc_mask,
   input  logic [MISC_W-1:0]  misc_stat,
   input  logic [N_BANKS-1:0] overview,
   output logic [N_BANKS-1:0] fifo_clr,
   output logic               misc_clr,
   output logic [DATA_W-1:0]  rdata
);

   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (addr == ADDR_W'(CTRL_ADDR))      rd_val = DATA_W'(ctrl);
      if (addr == ADDR_W'(MISC_MASK_ADDR)) rd_val = DATA_W'(misc_mask);
      if (addr == ADDR_W'(MISC_STAT_ADDR)) rd_val = DATA_W'(misc_stat);
      if (addr == ADDR_W'(OVW_ADDR))       rd_val = DATA_W'(overview);
      for (int k = 0; k < N_BANKS; k++) begin
         if (addr == ADDR_W'(FMASK_BASE + k)) rd_val = DATA_W'(fifo_mask[k*BANK_W +: BANK_W]);
         if (addr == ADDR_W'(FSTAT_BASE + k)) rd_val = DATA_W'(fifo_stat[k*BANK_W +: BANK_W]);
      end
   end

   assign misc_clr = rd && (addr == ADDR_W'(MISC_STAT_ADDR));

   generate
      for (genvar k = 0; k < N_BANKS; k++) begin : g_clr
         assign fifo_clr[k] = rd && (addr == ADDR_W'(FSTAT_BASE + k));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         rdata <= rd_val;
      end
   end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int unsigned N_BANKS = 8,
   parameter int unsigned BANK_W  = 8,
   parameter int unsigned MISC_W  = 8,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned N_FIFO = N_BANKS * BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_FIFO-1:0] fifo_evt,
   input  logic [MISC_W-1:0] misc_evt,
   output logic              irq_n
);

   generate
      if (N_BANKS < 1 || N_BANKS > MAX_BANKS) begin : g_bad_banks
         $error("irq_aggregator: N_BANKS out of range");
      end
      if (BANK_W > DATA_W || MISC_W > DATA_W || N_BANKS > DATA_W || DATA_W < 2) begin : g_bad_data
         $error("irq_aggregator: a register is wider than the data bus");
      end
      if ((1 << ADDR_W) < FSTAT_BASE + MAX_BANKS) begin : g_bad_addr
         $error("irq_aggregator: ADDR_W too small for the register map");
      end
   endgenerate

   irq_ctrl_t          ctrl;
   logic [N_FIFO-1:0]  fifo_mask;
   logic [N_FIFO-1:0]  fifo_stat;
   logic [MISC_W-1:0]  misc_mask;
   logic [MISC_W-1:0]  misc_stat;
   logic [N_BANKS-1:0] overview;
   logic [N_BANKS-1:0] fifo_clr;
   logic               misc_clr;

   irq_cfg_regs #(
      .N_BANKS(N_BANKS), .BANK_W(BANK_W), .MISC_W(MISC_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (bus_addr),
      .wr        (bus_wr),
      .wdata     (bus_wdata),
      .ctrl      (ctrl),
      .fifo_mask (fifo_mask),
      .misc_mask (misc_mask)
   );

   generate
      for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
         irq_status_bank #(.W(BANK_W), .MASK_GATES_LATCH(1'b1)) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (fifo_evt[k*BANK_W +: BANK_W]),
            .mask  (fifo_mask[k*BANK_W +: BANK_W]),
            .clr   (fifo_clr[k]),
            .stat  (fifo_stat[k*BANK_W +: BANK_W])
         );
         assign overview[k] = |fifo_stat[k*BANK_W +: BANK_W];
      end
   endgenerate

   irq_status_bank #(.W(MISC_W), .MASK_GATES_LATCH(1'b0)) misc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (misc_evt),
      .mask  (misc_mask),
      .clr   (misc_clr),
      .stat  (misc_stat)
   );

   irq_read_port #(
      .N_BANKS(N_BANKS), .BANK_W(BANK_W), .MISC_W(MISC_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) rdp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (bus_addr),
      .rd        (bus_rd),
      .ctrl      (ctrl),
      .fifo_mask (fifo_mask),
      .fifo_stat (fifo_stat),
      .misc_mask (misc_mask),
      .misc_stat (misc_stat),
      .overview  (overview),
      .fifo_clr  (fifo_clr),
      .misc_clr  (misc_clr),
      .rdata     (bus_rdata)
   );

   logic fifo_pend;
   logic misc_pend;

   assign fifo_pend = ctrl.fifo_grp_en && |(fifo_stat & fifo_mask);
   assign misc_pend = |(misc_stat & misc_mask);
   assign irq_n     = !(ctrl.glob_en && (fifo_pend || misc_pend));

endmodule

module irq_aggregator_chk
   import irq_agg_pkg::*;
#(
   parameter int unsigned N_BANKS = 8,
   parameter int unsigned BANK_W  = 8,
   parameter int unsigned MISC_W  = 8,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned N_FIFO = N_BANKS * BANK_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [N_FIFO-1:0] fifo_evt,
   input logic [MISC_W-1:0] misc_evt,
   input logic              irq_n,
   input logic [1:0]        ctrl_bits,
   input logic [N_FIFO-1:0] fifo_mask,
   input logic [N_FIFO-1:0] fifo_stat,
   input logic [MISC_W-1:0] misc_stat
);

   logic [N_BANKS-1:0] bank_any;
   logic [N_FIFO-1:0]  fifo_admit;

   assign fifo_admit = fifo_evt & fifo_mask;

   generate
      for (genvar k = 0; k < N_BANKS; k++) begin : g_any
         assign bank_any[k] = |fifo_stat[k*BANK_W +: BANK_W];
      end
   endgenerate

   // R2
   fifo_mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((fifo_stat & ~$past(fifo_stat)) & ~$past(fifo_mask)) == '0);

   // R6
   fifo_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_stat & $past(fifo_admit)) == $past(fifo_admit));

   // R3
   misc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (misc_stat & $past(misc_evt)) == $past(misc_evt));

   // R4
   ovw_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OVW_ADDR)) |=>
         (fifo_stat & $past(fifo_stat)) == $past(fifo_stat));

   // R4
   ovw_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OVW_ADDR)) |=>
         bus_rdata == DATA_W'($past(bank_any)));

   // R9
   write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_rd) |=>
         ((fifo_stat & $past(fifo_stat)) == $past(fifo_stat)) &&
         ((misc_stat & $past(misc_stat)) == $past(misc_stat)));

   // R5
   misc_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(MISC_STAT_ADDR)) |=>
         bus_rdata == DATA_W'($past(misc_stat)));

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_bits[0] |-> irq_n);

   // R7
   irq_fifo_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits == 2'b11 && (fifo_stat & fifo_mask) != '0) |-> !irq_n);

endmodule

bind irq_aggregator irq_aggregator_chk #(
   .N_BANKS(N_BANKS), .BANK_W(BANK_W), .MISC_W(MISC_W),
   .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .fifo_evt  (fifo_evt),
   .misc_evt  (misc_evt),
   .irq_n     (irq_n),
   .ctrl_bits (ctrl),
   .fifo_mask (fifo_mask),
   .fifo_stat (fifo_stat),
   .misc_stat (misc_stat)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [63:0] fifo_evt = '0;
   logic [7:0]  misc_evt = '0;
   logic        irq_n;

   int n_chk  = 0;
   int n_fail = 0;

   // Bench model of the register state
   logic [7:0] m_fstat [8];
   logic [7:0] m_fmask [8];
   logic [7:0] m_mstat;
   logic [7:0] m_mmask;
   logic [1:0] m_ctrl;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_aggregator dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .fifo_evt  (fifo_evt),
      .misc_evt  (misc_evt),
      .irq_n     (irq_n)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model_read(input logic [4:0] a);
      logic [7:0] v = 8'h00;
      if (a == 5'd0) v = {6'b0, m_ctrl};
      if (a == 5'd1) v = m_mmask;
      if (a == 5'd2) v = m_mstat;
      if (a == 5'd3) for (int k = 0; k < 8; k++) v[k] = |m_fstat[k];
      if (a >= 5'd8 && a < 5'd16) v = m_fmask[a - 5'd8];
      if (a >= 5'd16 && a < 5'd24) v = m_fstat[a - 5'd16];
      return v;
   endfunction

   function automatic logic model_irq_n();
      logic fp = 1'b0;
      for (int k = 0; k < 8; k++) fp |= |(m_fstat[k] & m_fmask[k]);
      return !(m_ctrl[0] && ((m_ctrl[1] && fp) || |(m_mstat & m_mmask)));
   endfunction

   // One bus cycle: drive at the falling edge, update the model at the
   // rising edge, compare shortly after it
   task automatic step(input logic [4:0] a, input logic r, input logic w,
                       input logic [7:0] d, input logic [63:0] fe, input logic [7:0] me);
      logic [7:0] exp_rd;
      @(negedge clk);
      bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
      fifo_evt = fe; misc_evt = me;
      exp_rd = model_read(a);
      @(posedge clk);
      for (int k = 0; k < 8; k++) begin
         m_fstat[k] = ((r && a == 5'(16 + k)) ? 8'h00 : m_fstat[k]) | (fe[k*8 +: 8] & m_fmask[k]);
      end
      m_mstat = ((r && a == 5'd2) ? 8'h00 : m_mstat) | me;
      if (w) begin
         if (a == 5'd0) m_ctrl = d[1:0];
         if (a == 5'd1) m_mmask = d;
         if (a >= 5'd8 && a < 5'd16) m_fmask[a - 5'd8] = d;
      end
      #1;
      bus_rd = 1'b0; bus_wr = 1'b0; fifo_evt = '0; misc_evt = '0;
      if (r) check("R5/R8 read data", bus_rdata, exp_rd);
      check("R7 irq_n", {7'b0, irq_n}, {7'b0, model_irq_n()});
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      step(a, 1'b0, 1'b1, d, '0, '0);
   endtask

   task automatic rd(input logic [4:0] a, input logic [63:0] fe, input logic [7:0] me,
                     output logic [7:0] got);
      step(a, 1'b1, 1'b0, 8'h00, fe, me);
      got = bus_rdata;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] got;
      void'($urandom(32'h5EED_1234));
      for (int k = 0; k < 8; k++) begin m_fstat[k] = '0; m_fmask[k] = '0; end
      m_mstat = '0; m_mmask = '0; m_ctrl = '0;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 rdata after reset", bus_rdata, 8'h00);
      check("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
      for (int a = 0; a < 24; a++) begin
         rd(5'(a), '0, '0, got);
         check("R1 register after reset", got, 8'h00);
      end

      // R8 control bits, readback and unmapped addresses
      wr(5'd0, 8'hFF);
      rd(5'd0, '0, '0, got);
      check("R8 ctrl upper bits zero", got, 8'h03);
      wr(5'd0, 8'h00);
      wr(5'd9, 8'hA5);
      rd(5'd9, '0, '0, got);
      check("R8 mask readback", got, 8'hA5);
      rd(5'd30, '0, '0, got);
      check("R8 unmapped reads zero", got, 8'h00);

      // R2 masked-off channel does not latch
      step(5'd0, 1'b0, 1'b0, 8'h00, 64'hFF << 16, '0);
      rd(5'd18, '0, '0, got);
      check("R2 masked channel ignored", got, 8'h00);
      wr(5'd10, 8'h0F);
      step(5'd0, 1'b0, 1'b0, 8'h00, 64'hFF << 16, '0);
      rd(5'd18, '0, '0, got);
      check("R2 only mask-enabled bits latch", got, 8'h0F);
      rd(5'd18, '0, '0, got);
      check("R5 read clears bank", got, 8'h00);

      // R3 misc latches with mask zero, pin stays high
      wr(5'd0, 8'h03);
      step(5'd0, 1'b0, 1'b0, 8'h00, '0, 8'h81);
      check("R7 misc unmasked no irq", {7'b0, irq_n}, 8'h01);
      rd(5'd2, '0, '0, got);
      check("R3 misc latched while masked", got, 8'h81);

      // R4 overview does not clear
      wr(5'd13, 8'hFF);
      step(5'd0, 1'b0, 1'b0, 8'h00, 64'h04 << 40, '0);
      rd(5'd3, '0, '0, got);
      check("R4 overview bank5", got, 8'h20);
      rd(5'd3, '0, '0, got);
      check("R4 overview read not clearing", got, 8'h20);
      check("R7 fifo enabled pending", {7'b0, irq_n}, 8'h00);
      wr(5'd0, 8'h01);
      check("R7 fifo group disabled", {7'b0, irq_n}, 8'h01);
      wr(5'd0, 8'h03);

      // R9 writes to status and overview ignored
      wr(5'd21, 8'h00);
      wr(5'd3, 8'h00);
      wr(5'd2, 8'hFF);
      rd(5'd2, '0, '0, got);
      check("R9 misc status write ignored", got, 8'h00);
      rd(5'd21, '0, '0, got);
      check("R9 bank status write ignored", got, 8'h04);

      // R6 event during clearing read survives
      wr(5'd11, 8'hFF);
      rd(5'd19, 64'h10 << 24, '0, got);
      check("R6 event not in same read", got, 8'h00);
      rd(5'd19, '0, '0, got);
      check("R6 event on next read", got, 8'h10);
      step(5'd0, 1'b0, 1'b0, 8'h00, 64'h01 << 24, 8'h02);
      rd(5'd19, 64'h02 << 24, '0, got);
      check("R6 old bit returned", got, 8'h01);
      rd(5'd19, '0, '0, got);
      check("R6 new bit kept", got, 8'h02);
      rd(5'd2, '0, 8'h40, got);
      check("R6 misc old bit", got, 8'h02);
      rd(5'd2, '0, '0, got);
      check("R6 misc new bit", got, 8'h40);

      // Random phase, checked against the model on every step
      for (int i = 0; i < 4000; i++) begin
         logic [63:0] fe;
         logic [7:0]  me;
         int unsigned op;
         fe = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         me = 8'($urandom) & 8'($urandom) & 8'($urandom);
         op = $urandom % 8;
         if (op < 2)      step(5'd0, 1'b0, 1'b0, 8'h00, fe, me);
         else if (op < 4) step(5'($urandom % 32), 1'b1, 1'b0, 8'h00, fe, me);
         else if (op < 6) step(5'(16 + $urandom % 8), 1'b1, 1'b0, 8'h00, fe, me);
         else             step(5'($urandom % 24), 1'b0, 1'b1, 8'($urandom), fe, me);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule